// File: doc/BRIEF.md
# DMA Stream FIFO Control Register Slice

This block holds the per-stream registers of one DMA channel that moves data through a small FIFO. It has two 32-bit memory base-address registers and a FIFO control register. The control register carries an error-interrupt enable, a FIFO/direct mode bit, a threshold selector and a read-only fill-level code. The fill-level code comes from the FIFO occupancy count that the data mover supplies. Software reaches the registers over a simple zero-wait bus with byte strobes. The data mover reads the stored bases, the threshold, the mode and a threshold-reached flag directly from the outputs.

Some writes depend on stream state. The base addresses can be changed while the stream is idle. They can also be changed while it runs in dual-buffer mode with the current-target flag set to 1, so software can reload the buffer that is not in use. The threshold can only be changed while the stream is idle. A memory-to-memory direction on an enabled stream makes the hardware switch to FIFO mode.

The register map uses word offsets on `reg_addr`:
- 0: memory base 0
- 1: memory base 1
- 2: FIFO control
- 3: unmapped, reads zero

Top module: `dma_fifo_ctl_regs`

## Requirements
- R1: After reset, both base registers read 0 and the control register reads 0x00000021: threshold 01, status 100, mode 0, interrupt enable 0.
- R2: A write to a base register updates only the bytes whose strobe bit is set. `wr_be[k]` covers bits 8k+7..8k.
- R3: A base-register write takes effect only when `stream_en` is 0, or when both `dual_buf` and `cur_target` are 1. Otherwise the register keeps its value.
- R4: Control bits 5:3 report the fill level for a FIFO of DEPTH entries:
  - 100 when the count is 0
  - 101 when the count is at least DEPTH
  - 011 when the count is at least 3*DEPTH/4
  - 010 when the count is at least DEPTH/2
  - 001 when the count is at least DEPTH/4
  - 000 otherwise
  Codes 110 and 111 never appear.
- R5: Control bits 1:0 select the threshold: 00 is 1/4, 01 is 1/2, 10 is 3/4 and 11 is full. A write changes them only while `stream_en` is 0. They drive `thresh_sel`.
- R6: Control bit 2 (1 = FIFO mode, 0 = direct mode) is software-writable. One edge after `stream_en` is 1 with `xfer_dir` equal to 10, it reads 1. While that condition holds, a write of 0 is ignored.
- R7: `thresh_hit` is 1 exactly when FIFO mode is active and the occupancy count is at least the selected fraction of DEPTH.
- R8: Control bit 7 is a read/write interrupt enable that drives `ferr_ie`. Bits 31:8 and bit 6 read 0. Writes to bits 5:3 have no effect.
- R9: `rd_data` shows the addressed register in the same cycle that `rd_en` is high. It is 0 when `rd_en` is low or the offset is 3.
- R10: Only strobe bit 0 affects the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Word offset of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, same cycle |
| stream_en | input | 1 | Stream enabled |
| dual_buf | input | 1 | Dual-buffer mode |
| cur_target | input | 1 | Current target buffer flag |
| xfer_dir | input | 2 | Transfer direction, 10 = memory-to-memory |
| fifo_cnt | input | $clog2(DEPTH+1) | FIFO occupancy count |
| mem0_base | output | 32 | Memory base 0 |
| mem1_base | output | 32 | Memory base 1 |
| thresh_sel | output | 2 | Selected threshold |
| fifo_mode | output | 1 | 1 = FIFO mode, 0 = direct mode |
| ferr_ie | output | 1 | FIFO error interrupt enable |
| thresh_hit | output | 1 | Occupancy at or above the selected threshold in FIFO mode |

## Verification
The status code and `thresh_hit` are combinational from the count. A wrong band edge therefore shows up on a read in the same cycle at one specific count, which is why the count is swept across every value from 0 to DEPTH. A write accepted in a stream state where it should be blocked, or a byte lane applied to the wrong place, corrupts a stored value. That error shows on `mem0_base`, `mem1_base` or `thresh_sel` one edge after the write, and it persists until the next legal write. A missed forcing of the mode bit shows on `fifo_mode` one edge after the memory-to-memory condition appears.

// File: rtl/dma_fifo_ctl_regs.sv
module dma_fifo_ctl_regs #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  input  logic          stream_en,
  input  logic          dual_buf,
  input  logic          cur_target,
  input  logic [1:0]    xfer_dir,
  input  logic [CW-1:0] fifo_cnt,
  output logic [31:0]   mem0_base,
  output logic [31:0]   mem1_base,
  output logic [1:0]    thresh_sel,
  output logic          fifo_mode,
  output logic          ferr_ie,
  output logic          thresh_hit
);

  localparam logic [1:0] A_M0 = 2'd0;
  localparam logic [1:0] A_M1 = 2'd1;
  localparam logic [1:0] A_FC = 2'd2;
  localparam int Q1 = DEPTH / 4;
  localparam int Q2 = DEPTH / 2;
  localparam int Q3 = (3 * DEPTH) / 4;

  logic [31:0] bmask;
  logic        base_open, force_fifo;
  logic [2:0]  lvl;
  logic [CW:0] cnt_x, thr_lim;

  assign bmask      = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};
  assign base_open  = !stream_en || (dual_buf && cur_target);
  assign force_fifo = stream_en && (xfer_dir == 2'b10);
  assign cnt_x      = {1'b0, fifo_cnt};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mem0_base <= '0;
      mem1_base <= '0;
    end else if (wr_en && base_open) begin
      if (reg_addr == A_M0) mem0_base <= (mem0_base & ~bmask) | (wr_data & bmask);
      if (reg_addr == A_M1) mem1_base <= (mem1_base & ~bmask) | (wr_data & bmask);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thresh_sel <= 2'b01;
      fifo_mode  <= 1'b0;
      ferr_ie    <= 1'b0;
    end else begin
      if (wr_en && wr_be[0] && reg_addr == A_FC) begin
        ferr_ie <= wr_data[7];
        fifo_mode <= wr_data[2];
        if (!stream_en) thresh_sel <= wr_data[1:0];
      end
      if (force_fifo) fifo_mode <= 1'b1;
    end

  always_comb begin
    if (fifo_cnt == '0)             lvl = 3'b100;
    else if (cnt_x >= (CW+1)'(DEPTH)) lvl = 3'b101;
    else if (cnt_x >= (CW+1)'(Q3))  lvl = 3'b011;
    else if (cnt_x >= (CW+1)'(Q2))  lvl = 3'b010;
    else if (cnt_x >= (CW+1)'(Q1))  lvl = 3'b001;
    else                            lvl = 3'b000;
  end

  always_comb
    case (thresh_sel)
      2'b00:   thr_lim = (CW+1)'(Q1);
      2'b01:   thr_lim = (CW+1)'(Q2);
      2'b10:   thr_lim = (CW+1)'(Q3);
      default: thr_lim = (CW+1)'(DEPTH);
    endcase

  assign thresh_hit = fifo_mode && (cnt_x >= thr_lim);

  always_comb begin
    rd_data = '0;
    if (rd_en)
      case (reg_addr)
        A_M0:    rd_data = mem0_base;
        A_M1:    rd_data = mem1_base;
        A_FC:    rd_data = {24'd0, ferr_ie, 1'b0, lvl, fifo_mode, thresh_sel};
        default: rd_data = '0;
      endcase
  end

  // R3
  base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_en && !(dual_buf && cur_target)) |=> ($stable(mem0_base) && $stable(mem1_base)));

  // R5
  thr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_en |=> $stable(thresh_sel));

  // R6
  m2m_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_en && xfer_dir == 2'b10) |=> fifo_mode);

  // R7
  direct_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !thresh_hit);

  // R4
  empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == A_FC && fifo_cnt == '0) |-> (rd_data[5:3] == 3'b100));

  // R8
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == A_FC) |-> (rd_data[31:8] == '0 && !rd_data[6] && rd_data[5:4] != 2'b11));

endmodule

// File: tb/sim_dma_fifo_ctl_regs.sv
module sim_dma_fifo_ctl_regs;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] rd_data;
  logic stream_en = 0, dual_buf = 0, cur_target = 0;
  logic [1:0] xfer_dir = 0;
  logic [CW-1:0] fifo_cnt = 0;
  logic [31:0] mem0_base, mem1_base;
  logic [1:0] thresh_sel;
  logic fifo_mode, ferr_ie, thresh_hit;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] e0, e1, v;

  always #4 clk = ~clk;

  dma_fifo_ctl_regs #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_be = b; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_be = 0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [31:0] r);
    @(negedge clk);
    reg_addr = a; rd_en = 1;
    #1 r = rd_data;
    rd_en = 0;
  endtask

  function automatic logic [2:0] lvl_of(input int c);
    if (c == 0) return 3'b100;
    if (c >= DEPTH) return 3'b101;
    if (c >= 3 * DEPTH / 4) return 3'b011;
    if (c >= DEPTH / 2) return 3'b010;
    if (c >= DEPTH / 4) return 3'b001;
    return 3'b000;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    do_rd(0, v); chk("R1 m0", v, 0);
    do_rd(1, v); chk("R1 m1", v, 0);
    do_rd(2, v); chk("R1 ctrl", v, 32'h21);
    chk("R1 thresh_sel", {30'd0, thresh_sel}, 1);
    // R9 unmapped and idle read
    do_rd(3, v); chk("R9 unmapped", v, 0);
    @(negedge clk); reg_addr = 2; rd_en = 0; #1 chk("R9 rd_en low", rd_data, 0);

    // R2 byte strobes
    e0 = 0; e1 = 0;
    for (int b = 0; b < 16; b++) begin
      logic [31:0] d, m;
      d = 32'hA1B2C3D4 ^ (b * 32'h01010101);
      m = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
      do_wr(0, d, b[3:0]); e0 = (e0 & ~m) | (d & m);
      do_wr(1, ~d, b[3:0]); e1 = (e1 & ~m) | (~d & m);
      do_rd(0, v); chk("R2 m0", v, e0);
      do_rd(1, v); chk("R2 m1", v, e1);
    end

    // R3 gating by stream state
    for (int s = 0; s < 8; s++) begin
      bit ok;
      stream_en = s[2]; dual_buf = s[1]; cur_target = s[0];
      ok = !s[2] || (s[1] && s[0]);
      do_wr(0, 32'h1000 + s, 4'hF); if (ok) e0 = 32'h1000 + s;
      do_wr(1, 32'h2000 + s, 4'hF); if (ok) e1 = 32'h2000 + s;
      chk("R3 mem0_base", mem0_base, e0);
      chk("R3 mem1_base", mem1_base, e1);
    end
    stream_en = 0; dual_buf = 0; cur_target = 0;

    // R8 control bits; status not writable
    do_wr(2, 32'hFFFFFFFF, 4'h1);
    do_rd(2, v); chk("R8 ctrl all ones", v, 32'hA7);
    chk("R8 ferr_ie", {31'd0, ferr_ie}, 1);
    // R10 upper strobes alone do nothing
    do_wr(2, 32'h0, 4'hE);
    do_rd(2, v); chk("R10 ctrl upper lanes", v, 32'hA7);
    do_wr(2, 32'h0, 4'h1);
    do_rd(2, v); chk("R8 ctrl cleared", v, 32'h20);

    // R5 threshold locked while enabled
    do_wr(2, 32'h1, 4'h1);
    stream_en = 1;
    do_wr(2, 32'h2, 4'h1);
    chk("R5 thresh locked", {30'd0, thresh_sel}, 1);
    do_rd(2, v); chk("R5 ctrl locked", v, 32'h21);
    stream_en = 0;
    do_wr(2, 32'h2, 4'h1);
    chk("R5 thresh written", {30'd0, thresh_sel}, 2);

    // R6 hardware forcing of FIFO mode
    @(negedge clk); stream_en = 1; xfer_dir = 2'b10;
    @(negedge clk); chk("R6 forced", {31'd0, fifo_mode}, 1);
    do_wr(2, 32'h0, 4'h1);
    chk("R6 clear ignored", {31'd0, fifo_mode}, 1);
    @(negedge clk); stream_en = 0; xfer_dir = 2'b00;
    do_wr(2, 32'h0, 4'h1);
    chk("R6 cleared when idle", {31'd0, fifo_mode}, 0);
    stream_en = 1; xfer_dir = 2'b01;
    @(negedge clk); @(negedge clk);
    chk("R6 no force other dir", {31'd0, fifo_mode}, 0);
    stream_en = 0; xfer_dir = 0;

    // R4 / R7 sweep
    for (int md = 0; md < 2; md++)
      for (int t = 0; t < 4; t++) begin
        int lim;
        do_wr(2, md * 4 + t, 4'h1);
        lim = (t == 0) ? DEPTH / 4 : (t == 1) ? DEPTH / 2 : (t == 2) ? 3 * DEPTH / 4 : DEPTH;
        for (int c = 0; c <= DEPTH; c++) begin
          @(negedge clk); fifo_cnt = c[CW-1:0];
          do_rd(2, v);
          chk("R4 status", {29'd0, v[5:3]}, {29'd0, lvl_of(c)});
          chk("R7 thresh_hit", {31'd0, thresh_hit}, {31'd0, (md == 1) && (c >= lim)});
        end
      end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule